// File: doc/BRIEF.md
# UART Status and Interrupt Front End

This block is the register-side front end of a serial port. It owns the two character queues (one outbound, one inbound), the sticky receive error flags, the modem-input change flag, the interrupt enable masks and the single level interrupt line. The bit shifters and the baud generator sit outside. The receiver hands characters and error strobes in. The transmitter takes characters from a valid/ready stream. Line control, modem control and the baud divisor are held here and driven out as plain pins.

Software reaches the block through a word-wide register port. It has a select, a write flag, a byte address with bits 5:2 picking the word, and write data. Read data is combinational from the current state in the cycle the read is presented. Read side effects (popping the inbound queue, clearing sticky flags) and all writes take effect at the rising edge that ends that cycle.

The inbound character port has no back-pressure. A strobe on `rx_valid` is always consumed. When the queue is full the character is discarded and an overrun is recorded. The outbound port is valid/ready. `tx_valid` is high while the outbound queue holds anything, and `tx_data` is the oldest entry. An entry leaves only at an edge where both `tx_valid` and `tx_ready` are high. While `tx_ready` stays low, `tx_valid` and `tx_data` hold.

Top module: `uart_stat_irq`

## Requirements
- R1: After reset the line status word reads 0x41, the interrupt word reads 0x01, both occupancy words and all control words read 0, `tx_valid` is 0 and `irq` is 0.
- R2: A write to word 0 appends bits 7:0 to the outbound queue, which has FIFO_DEPTH entries. A write when the queue is full is dropped. Entries leave on `tx_data` in write order, one per edge with `tx_valid` and `tx_ready` both high, and hold while `tx_ready` is low.
- R3: Line status bit 0 is 1 while the outbound queue is not full. Bit 6 is 1 only while it is completely empty.
- R4: A read of word 0 returns the oldest inbound character and removes it. A read of word 0 with the inbound queue empty returns 0 and changes nothing.
- R5: Word 8 reads the outbound occupancy and word 9 reads the inbound occupancy. Line status bit 1 is 1 while the inbound queue is not empty.
- R6: Line status bits 2, 3, 4 and 5 are sticky flags for parity error, overrun, framing error and break. A read of line status clears them at its edge, except that a strobe in that same cycle leaves its flag set.
- R7: An `rx_valid` strobe while the inbound queue holds FIFO_DEPTH entries discards the character and sets the overrun flag (line status bit 3).
- R8: Any write to word 9 empties the inbound queue. A character strobed in that same cycle is discarded without an overrun.
- R9: In word 7, bits 7:4 are the read/write enables for the modem, line-status, receive and transmit sources in that order. Bits 3:0 are the matching live flags and ignore writes.
- R10: The transmit flag (bit 0) is outbound-not-full, the receive flag (bit 1) is inbound-not-empty, and the line flag (bit 2) is the OR of the four sticky errors. The modem flag (bit 3) sets when `modem_in` differs from its value at the previous edge and clears on a read of word 2. Word 2 bits 3:0 read the registered `modem_in`.
- R11: `irq` is the OR over the four sources of flag AND enable, so writing 0 to word 7 forces `irq` low from the next cycle.
- R12: Words 3 and 4 hold 8-bit line and modem control, word 5 a 16-bit divisor low part and word 6 an 8-bit high part. They read back masked to those widths and drive `line_ctrl`, `modem_ctrl` and `baud_div` = {high, low}. Writes to words 1, 2 and 8 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address, bits 5:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational in the read cycle |
| rx_valid | input | 1 | Received character strobe, no back-pressure |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity error strobe |
| rx_ferr | input | 1 | Framing error strobe |
| rx_brk | input | 1 | Break condition strobe |
| tx_valid | output | 1 | Outbound queue has a character |
| tx_ready | input | 1 | Transmitter takes the character this edge |
| tx_data | output | 8 | Oldest outbound character |
| modem_in | input | 4 | Modem status inputs |
| line_ctrl | output | 8 | Line control word |
| modem_ctrl | output | 8 | Modem control word |
| baud_div | output | 24 | Baud divisor {high, low} |
| irq | output | 1 | Level interrupt |

## Verification
Read data is due in the very cycle a read is presented, before its edge. The bench drives each access just after a falling edge and samples `bus_rdata` one nanosecond later. Everything a cycle's stimulus changes (queue contents, occupancy, sticky flags, enables, `irq`, the head on `tx_data`, control pins) is due after the following rising edge. So the bench checks `irq`, `tx_valid` and `tx_data` at the next falling edge against a model that it advances exactly once per stimulus cycle. Simultaneous events in one cycle (pop with push, clearing read with a new error, flush with an arriving character, a write into a full queue) are each placed in a single cycle on purpose so their ordering is checked.

// File: rtl/uart_si_pkg.sv
package uart_si_pkg;
  // word indices (bus_addr[5:2])
  localparam logic [3:0] IDX_DATA  = 4'd0;
  localparam logic [3:0] IDX_LSR   = 4'd1;
  localparam logic [3:0] IDX_MSR   = 4'd2;
  localparam logic [3:0] IDX_LCR   = 4'd3;
  localparam logic [3:0] IDX_MCR   = 4'd4;
  localparam logic [3:0] IDX_DIVL  = 4'd5;
  localparam logic [3:0] IDX_DIVH  = 4'd6;
  localparam logic [3:0] IDX_ISC   = 4'd7;
  localparam logic [3:0] IDX_TXCNT = 4'd8;
  localparam logic [3:0] IDX_RXCNT = 4'd9;

  // interrupt source order (flag bit i, enable bit i+NSRC)
  localparam int NSRC   = 4;
  localparam int SRC_TX = 0;
  localparam int SRC_RX = 1;
  localparam int SRC_LS = 2;
  localparam int SRC_MS = 3;

  // sticky error vector order; lands on line status bits 5:2
  localparam int ERR_PE  = 0;
  localparam int ERR_OE  = 1;
  localparam int ERR_FE  = 2;
  localparam int ERR_BRK = 3;
  localparam int NERR    = 4;
endpackage

// File: rtl/usi_fifo.sv
module usi_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 128,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  // a push is taken only into a queue that was not full at the cycle start
  assign push_ok = push & ~full & ~flush;
  assign pop_ok  = pop & ~empty & ~flush;
  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign head    = mem[rp];

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= step(wp);
      if (pop_ok)  rp <= step(rp);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/usi_line_stat.sv
module usi_line_stat import uart_si_pkg::*; #(
  parameter int MW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            perr,
  input  logic            ferr,
  input  logic            brk,
  input  logic            ovr,
  input  logic            lsr_rd,
  input  logic [MW-1:0]   modem_in,
  input  logic            msr_rd,
  output logic [NERR-1:0] err,
  output logic [MW-1:0]   modem_q,
  output logic            ms_flag
);
  logic [NERR-1:0] hit;

  always_comb begin
    hit          = '0;
    hit[ERR_PE]  = perr;
    hit[ERR_OE]  = ovr;
    hit[ERR_FE]  = ferr;
    hit[ERR_BRK] = brk;
  end

  // clear-on-read, a strobe in the reading cycle wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err     <= '0;
      modem_q <= '0;
      ms_flag <= 1'b0;
    end else begin
      err     <= (lsr_rd ? '0 : err) | hit;
      modem_q <= modem_in;
      ms_flag <= (msr_rd ? 1'b0 : ms_flag) | (modem_in != modem_q);
    end
  end
endmodule

// File: rtl/usi_irq_ctrl.sv
module usi_irq_ctrl import uart_si_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_wdata,
  input  logic [NSRC-1:0] flags,
  output logic [NSRC-1:0] mask,
  output logic            irq
);
  logic [NSRC-1:0] hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= '0;
    else if (mask_we) mask <= mask_wdata;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign hit[i] = flags[i] & mask[i];
  end

  assign irq = |hit;
endmodule

// File: rtl/uart_stat_irq.sv
module uart_stat_irq import uart_si_pkg::*; #(
  parameter int FIFO_DEPTH = 128,
  parameter int DATA_W     = 8,
  parameter int MODEM_W    = 4,
  parameter int DIVL_W     = 16,
  parameter int DIVH_W     = 8,
  parameter int CTRL_W     = 8,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_sel,
  input  logic                     bus_wr,
  input  logic [5:0]               bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic                     rx_valid,
  input  logic [DATA_W-1:0]        rx_data,
  input  logic                     rx_perr,
  input  logic                     rx_ferr,
  input  logic                     rx_brk,
  output logic                     tx_valid,
  input  logic                     tx_ready,
  output logic [DATA_W-1:0]        tx_data,
  input  logic [MODEM_W-1:0]       modem_in,
  output logic [CTRL_W-1:0]        line_ctrl,
  output logic [CTRL_W-1:0]        modem_ctrl,
  output logic [DIVH_W+DIVL_W-1:0] baud_div,
  output logic                     irq
);
  logic             wr_en, rd_en;
  logic [3:0]       ridx;
  logic             tx_push, rx_pop, rx_flush, rx_ovr, lsr_rd, msr_rd;
  logic [CNT_W-1:0] rx_cnt, tx_cnt;
  logic             rx_full, rx_empty, tx_full, tx_empty;
  logic [DATA_W-1:0] rx_head;
  logic [NERR-1:0]  lsr_err;
  logic [MODEM_W-1:0] modem_q;
  logic             ms_flag;
  logic [NSRC-1:0]  flags, mask;
  logic [DIVL_W-1:0] div_lo;
  logic [DIVH_W-1:0] div_hi;
  logic [6:0]       lsr_val;
  logic             unused_bits;

  assign wr_en    = bus_sel & bus_wr;
  assign rd_en    = bus_sel & ~bus_wr;
  assign ridx     = bus_addr[5:2];
  assign tx_push  = wr_en && (ridx == IDX_DATA);
  assign rx_pop   = rd_en && (ridx == IDX_DATA);
  assign rx_flush = wr_en && (ridx == IDX_RXCNT);
  assign lsr_rd   = rd_en && (ridx == IDX_LSR);
  assign msr_rd   = rd_en && (ridx == IDX_MSR);
  assign rx_ovr   = rx_valid & rx_full & ~rx_flush;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:16]};

  usi_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_txq (
    .clk, .rst_n,
    .flush     (1'b0),
    .push      (tx_push),
    .push_data (bus_wdata[DATA_W-1:0]),
    .pop       (tx_ready),
    .head      (tx_data),
    .count     (tx_cnt),
    .full      (tx_full),
    .empty     (tx_empty)
  );
  assign tx_valid = ~tx_empty;

  usi_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_rxq (
    .clk, .rst_n,
    .flush     (rx_flush),
    .push      (rx_valid),
    .push_data (rx_data),
    .pop       (rx_pop),
    .head      (rx_head),
    .count     (rx_cnt),
    .full      (rx_full),
    .empty     (rx_empty)
  );

  usi_line_stat #(.MW(MODEM_W)) u_lstat (
    .clk, .rst_n,
    .perr     (rx_perr),
    .ferr     (rx_ferr),
    .brk      (rx_brk),
    .ovr      (rx_ovr),
    .lsr_rd   (lsr_rd),
    .modem_in (modem_in),
    .msr_rd   (msr_rd),
    .err      (lsr_err),
    .modem_q  (modem_q),
    .ms_flag  (ms_flag)
  );

  always_comb begin
    flags         = '0;
    flags[SRC_TX] = ~tx_full;
    flags[SRC_RX] = ~rx_empty;
    flags[SRC_LS] = |lsr_err;
    flags[SRC_MS] = ms_flag;
  end

  usi_irq_ctrl u_irq (
    .clk, .rst_n,
    .mask_we    (wr_en && (ridx == IDX_ISC)),
    .mask_wdata (bus_wdata[2*NSRC-1:NSRC]),
    .flags      (flags),
    .mask       (mask),
    .irq        (irq)
  );

  // control words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_ctrl  <= '0;
      modem_ctrl <= '0;
      div_lo     <= '0;
      div_hi     <= '0;
    end else if (wr_en) begin
      case (ridx)
        IDX_LCR:  line_ctrl  <= bus_wdata[CTRL_W-1:0];
        IDX_MCR:  modem_ctrl <= bus_wdata[CTRL_W-1:0];
        IDX_DIVL: div_lo     <= bus_wdata[DIVL_W-1:0];
        IDX_DIVH: div_hi     <= bus_wdata[DIVH_W-1:0];
        default: ;
      endcase
    end
  end
  assign baud_div = {div_hi, div_lo};

  assign lsr_val = {tx_empty, lsr_err, ~rx_empty, ~tx_full};

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (ridx)
        IDX_DATA:  bus_rdata = rx_empty ? '0 : 32'(rx_head);
        IDX_LSR:   bus_rdata = 32'(lsr_val);
        IDX_MSR:   bus_rdata = 32'(modem_q);
        IDX_LCR:   bus_rdata = 32'(line_ctrl);
        IDX_MCR:   bus_rdata = 32'(modem_ctrl);
        IDX_DIVL:  bus_rdata = 32'(div_lo);
        IDX_DIVH:  bus_rdata = 32'(div_hi);
        IDX_ISC:   bus_rdata = 32'({mask, flags});
        IDX_TXCNT: bus_rdata = 32'(tx_cnt);
        IDX_RXCNT: bus_rdata = 32'(rx_cnt);
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_stat_irq_chk.sv
module uart_stat_irq_chk import uart_si_pkg::*; #(
  parameter int DEPTH = 128,
  parameter int CW    = 8,
  parameter int DW    = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_sel,
  input logic            bus_wr,
  input logic [5:0]      bus_addr,
  input logic [31:0]     bus_wdata,
  input logic            rx_valid,
  input logic            tx_valid,
  input logic            tx_ready,
  input logic [DW-1:0]   tx_data,
  input logic            irq,
  input logic [CW-1:0]   rx_cnt,
  input logic [CW-1:0]   tx_cnt,
  input logic [NERR-1:0] lsr_err
);
  logic wr_isc, wr_flush, rd_lsr, rd_data;
  logic unused_chk;
  assign wr_isc   = bus_sel & bus_wr & (bus_addr[5:2] == IDX_ISC);
  assign wr_flush = bus_sel & bus_wr & (bus_addr[5:2] == IDX_RXCNT);
  assign rd_lsr   = bus_sel & ~bus_wr & (bus_addr[5:2] == IDX_LSR);
  assign rd_data  = bus_sel & ~bus_wr & (bus_addr[5:2] == IDX_DATA);
  assign unused_chk = ^{bus_addr[1:0], bus_wdata[31:8], bus_wdata[3:0]};

  assert_zero_mask_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_isc && bus_wdata[7:4] == 4'h0 |=> !irq);

  assert_overrun_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_cnt == CW'(DEPTH) && !wr_flush |=> lsr_err[ERR_OE]);

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_flush |=> rx_cnt == '0);

  assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_err[ERR_PE] && !rd_lsr |=> lsr_err[ERR_PE]);

  assert_pop_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data && rx_cnt != '0 && !rx_valid |=> rx_cnt == $past(rx_cnt) - 1'b1);

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH) && tx_cnt <= CW'(DEPTH));

  assert_empty_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt == '0 |-> !tx_valid);
endmodule

bind uart_stat_irq uart_stat_irq_chk #(.DEPTH(FIFO_DEPTH), .CW(CNT_W), .DW(DATA_W)) u_chk (.*);

// File: tb/uart_stat_irq_test.sv
module uart_stat_irq_test;
  localparam int DEPTH = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic [3:0]  modem_in = '0;
  logic [7:0]  line_ctrl, modem_ctrl;
  logic [23:0] baud_div;
  logic        irq;

  always #5 clk = ~clk;

  uart_stat_irq uut (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .rx_valid, .rx_data, .rx_perr, .rx_ferr, .rx_brk,
    .tx_valid, .tx_ready, .tx_data, .modem_in,
    .line_ctrl, .modem_ctrl, .baud_div, .irq
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model
  logic [7:0]  mtx[$];
  logic [7:0]  mrx[$];
  logic [3:0]  m_err = '0, m_mask = '0, m_modem = '0;
  logic        m_ms = 1'b0;
  logic [7:0]  m_lcr = '0, m_mcr = '0, m_divh = '0;
  logic [15:0] m_divl = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] m_flags();
    return {m_ms, |m_err, mrx.size() > 0, mtx.size() < DEPTH};
  endfunction

  function automatic logic exp_irq();
    return |(m_flags() & m_mask);
  endfunction

  function automatic logic [31:0] exp_read(input logic [3:0] idx);
    case (idx)
      4'd0: return (mrx.size() > 0) ? {24'b0, mrx[0]} : 32'b0;
      4'd1: return {25'b0, mtx.size() == 0, m_err, mrx.size() > 0, mtx.size() < DEPTH};
      4'd2: return {28'b0, m_modem};
      4'd3: return {24'b0, m_lcr};
      4'd4: return {24'b0, m_mcr};
      4'd5: return {16'b0, m_divl};
      4'd6: return {24'b0, m_divh};
      4'd7: return {24'b0, m_mask, m_flags()};
      4'd8: return 32'(mtx.size());
      4'd9: return 32'(mrx.size());
      default: return 32'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] idx);
    case (idx)
      4'd0: return "R4";
      4'd1: return "R6";
      4'd2: return "R10";
      4'd7: return "R9";
      4'd8, 4'd9: return "R5";
      default: return "R12";
    endcase
  endfunction

  // one clock cycle: check state, drive stimulus, check read data, advance model
  task automatic cycle(input bit sel, input bit wr, input logic [3:0] idx,
                       input logic [31:0] wd, input bit rxv, input logic [7:0] rxd,
                       input bit txr, input logic [2:0] errs, input logic [3:0] mdm,
                       input string tag);
    bit txpop, txpush, flush, rxpop, rxpush, ovr, rd;
    @(negedge clk);
    chk("R11", {31'b0, irq}, {31'b0, exp_irq()});
    chk("R2", {31'b0, tx_valid}, {31'b0, mtx.size() > 0});
    if (mtx.size() > 0) chk("R2", {24'b0, tx_data}, {24'b0, mtx[0]});
    bus_sel = sel; bus_wr = wr; bus_addr = {idx, 2'b00}; bus_wdata = wd;
    rx_valid = rxv; rx_data = rxd; tx_ready = txr;
    {rx_brk, rx_ferr, rx_perr} = errs; modem_in = mdm;
    #1;
    rd = sel && !wr;
    if (rd) chk((tag == "") ? tag_of(idx) : tag, bus_rdata, exp_read(idx));
    txpop  = txr && mtx.size() > 0;
    txpush = sel && wr && idx == 4'd0 && mtx.size() < DEPTH;
    flush  = sel && wr && idx == 4'd9;
    rxpop  = rd && idx == 4'd0 && mrx.size() > 0 && !flush;
    rxpush = rxv && !flush && mrx.size() < DEPTH;
    ovr    = rxv && !flush && mrx.size() == DEPTH;
    if (txpop) void'(mtx.pop_front());
    if (txpush) mtx.push_back(wd[7:0]);
    if (flush) mrx.delete();
    else begin
      if (rxpop) void'(mrx.pop_front());
      if (rxpush) mrx.push_back(rxd);
    end
    m_err = ((rd && idx == 4'd1) ? 4'b0 : m_err) | {errs[2], errs[1], ovr, errs[0]};
    m_ms  = ((rd && idx == 4'd2) ? 1'b0 : m_ms) | (mdm != m_modem);
    m_modem = mdm;
    if (sel && wr) begin
      case (idx)
        4'd3: m_lcr  = wd[7:0];
        4'd4: m_mcr  = wd[7:0];
        4'd5: m_divl = wd[15:0];
        4'd6: m_divh = wd[7:0];
        4'd7: m_mask = wd[7:4];
        default: ;
      endcase
    end
  endtask

  task automatic idle(input bit txr);
    cycle(0, 0, 4'd0, 0, 0, 0, txr, 3'b0, m_modem, "");
  endtask
  task automatic rd_reg(input logic [3:0] idx, input string tag);
    cycle(1, 0, idx, 0, 0, 0, 0, 3'b0, m_modem, tag);
  endtask
  task automatic wr_reg(input logic [3:0] idx, input logic [31:0] wd);
    cycle(1, 1, idx, wd, 0, 0, 0, 3'b0, m_modem, "");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20211119));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd_reg(4'd1, "R1"); rd_reg(4'd7, "R1"); rd_reg(4'd8, "R1"); rd_reg(4'd9, "R1");
    rd_reg(4'd0, "R1"); rd_reg(4'd3, "R1"); rd_reg(4'd5, "R1");

    // R12 control words and ignored writes
    wr_reg(4'd3, 32'hFFFF_FF3B); wr_reg(4'd4, 32'h0000_011F);
    wr_reg(4'd5, 32'h1234_ABCD); wr_reg(4'd6, 32'hFFFF_FF12);
    wr_reg(4'd1, 32'hFFFF_FFFF); wr_reg(4'd2, 32'hFFFF_FFFF); wr_reg(4'd8, 32'h0000_0055);
    idle(0);
    chk("R12", {24'b0, line_ctrl}, {24'b0, m_lcr});
    chk("R12", {24'b0, modem_ctrl}, {24'b0, m_mcr});
    chk("R12", {8'b0, baud_div}, {8'b0, m_divh, m_divl});
    rd_reg(4'd3, "R12"); rd_reg(4'd4, "R12"); rd_reg(4'd5, "R12"); rd_reg(4'd6, "R12");
    rd_reg(4'd1, "R12"); rd_reg(4'd8, "R12");

    // R9 / R11: masks writable, flags not
    wr_reg(4'd7, 32'h0000_00FF); rd_reg(4'd7, "R9");
    idle(0); idle(0);
    wr_reg(4'd7, 32'h0000_0000); idle(0); rd_reg(4'd7, "R11");

    // R2 / R3: fill outbound past full, then drain
    for (int i = 0; i < DEPTH + 2; i++) cycle(1, 1, 4'd0, 32'(i + 7), 0, 0, 0, 3'b0, m_modem, "R2");
    rd_reg(4'd1, "R3"); rd_reg(4'd8, "R5"); rd_reg(4'd7, "R10");
    for (int i = 0; i < DEPTH + 2; i++) idle(1);
    rd_reg(4'd1, "R3");

    // R7: overfill inbound
    for (int i = 0; i < DEPTH + 1; i++) cycle(0, 0, 4'd0, 0, 1, 8'(i ^ 8'h5A), 0, 3'b0, m_modem, "");
    rd_reg(4'd9, "R7"); rd_reg(4'd1, "R7"); rd_reg(4'd1, "R7");
    rd_reg(4'd0, "R4"); rd_reg(4'd0, "R4"); rd_reg(4'd9, "R5");

    // R8: flush with a character arriving in the same cycle
    cycle(1, 1, 4'd9, 0, 1, 8'hEE, 0, 3'b0, m_modem, "");
    rd_reg(4'd9, "R8"); rd_reg(4'd1, "R8"); rd_reg(4'd0, "R4");

    // R6: error strobes during a clearing read stay set
    cycle(1, 0, 4'd1, 0, 0, 0, 0, 3'b111, m_modem, "R6");
    rd_reg(4'd1, "R6"); rd_reg(4'd1, "R6");

    // R10: modem change flag
    wr_reg(4'd7, 32'h0000_0080);
    cycle(0, 0, 4'd0, 0, 0, 0, 0, 3'b0, 4'b1010, "");
    rd_reg(4'd7, "R10"); rd_reg(4'd2, "R10"); rd_reg(4'd7, "R10");
    wr_reg(4'd7, 32'h0000_00F0);

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [3:0] idx; bit sel, wr; logic [31:0] wd; logic [2:0] e; logic [3:0] md;
      r = int'($urandom_range(0, 99));
      sel = 1; wr = 0; wd = $urandom; idx = 4'd0;
      if      (r < 20) wr = 1;
      else if (r < 40) idx = 4'd0;
      else if (r < 50) idx = 4'd1;
      else if (r < 55) idx = 4'd7;
      else if (r < 58) begin idx = 4'd7; wr = 1; end
      else if (r < 60) idx = 4'd2;
      else if (r < 64) idx = 4'(8 + (r & 1));
      else if (r < 66) begin idx = 4'd9; wr = 1; end
      else if (r < 70) begin idx = 4'(3 + (r & 3)); wr = (r & 1) == 0; end
      else sel = 0;
      e[0] = ($urandom_range(0, 99) < 3);
      e[1] = ($urandom_range(0, 99) < 3);
      e[2] = ($urandom_range(0, 99) < 3);
      md = ($urandom_range(0, 99) < 2) ? 4'($urandom) : m_modem;
      cycle(sel, wr, idx, wd, $urandom_range(0, 99) < 35, 8'($urandom),
            $urandom_range(0, 1) == 1, e, md, "");
    end
    idle(0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule